// File: doc/BRIEF.md
# Programmable audio sample-rate divider

This block turns a master-clock enable into the frame timing of an audio converter. A 5-bit rate code and a mode bit (normal clocking or USB clocking) pick an integer divide ratio from a sparse table. An optional divide-by-two can be applied to the master clock before the rate division. The block counts enabled master-clock cycles and emits a one-cycle sample strobe at the start of every frame, together with a left/right frame clock.

Alongside the timing, the block reports which decimation filter class suits the active setting. It also raises a flag when the active rate is one of the high rates at which the 3D enhancement stage must be bypassed. A code with no meaning in the current mode is reported at once and otherwise ignored: the divider keeps its last valid setting. Any new code, mode or pre-divide setting is taken up only at a frame boundary, so a frame is never cut short.

Top module: `srate_div`

## Requirements
- R1: While reset is high and afterwards, sample_stb=0, frame_clk=0, filter_class=0 (class A) and bypass_3d=0 until the first counted tick. The block comes out of reset with ratio 256 (normal code 00000) active, and the first counted tick starts a frame.
- R2: In normal mode (usb_mode=0) the frame period in counted ticks is 256, 384, 768, 1152, 384, 576, 128, 192, 256, 384, 512, 768, 512, 768, 128 and 192 for codes 00000, 00001, 01010, 01011, 01100, 01101, 01110, 01111, 10000, 10001, 11010, 11011, 11100, 11101, 11110 and 11111 respectively.
- R3: In USB mode (usb_mode=1) the frame period is 250, 750, 375, 125, 272, 544, 500 and 136 counted ticks for codes 00000, 01010, 01100, 01110, 10001, 11011, 11100 and 11111 respectively.
- R4: With half_mclk=1, a counted tick occurs on every second mclk_en cycle, so a frame lasts 2N enabled cycles.
- R5: Only clock cycles with mclk_en=1 advance the divider. With mclk_en held low, no strobe or frame-clock change occurs.
- R6: sample_stb is high for exactly one clock cycle at the start of each frame, and frame_clk rises only in that same cycle.
- R7: frame_clk is high for floor(N/2) counted ticks from the start of the frame and low for the remaining N-floor(N/2) ticks.
- R8: filter_class encodes A=0, B=1, C=2 and D=3. In normal mode it is B for codes 01110, 01111, 11110 and 11111, and A for the other valid codes. In USB mode it is C for 00000, 01010, 01100 and 11100, A for 10001 and 11011, B for 11111, and D for 01110.
- R9: bypass_3d is 1 for the active normal-mode codes 01110, 01111, 11110 and 11111, and for the USB-mode codes 01110 and 11111. It is 0 for all other settings.
- R10: code_invalid is 1, in the same cycle, whenever the present rate_code is not listed for the present usb_mode. An invalid code leaves the ratio, filter_class, bypass_3d and pre-divide setting unchanged.
- R11: A change of rate_code, usb_mode or half_mclk takes effect only at the next frame boundary. The frame in progress completes with its old length, and filter_class and bypass_3d change only in a strobe cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_en | input | 1 | One-cycle enable marking each master-clock period |
| rate_code | input | 5 | Sample-rate selection code |
| usb_mode | input | 1 | 0 selects normal clocking, 1 selects USB clocking |
| half_mclk | input | 1 | Divide the master clock by two before rate division |
| sample_stb | output | 1 | One-cycle strobe at the start of each frame |
| frame_clk | output | 1 | Left/right frame clock |
| filter_class | output | 2 | Decimation filter class of the active setting (A=0..D=3) |
| bypass_3d | output | 1 | Active rate requires the 3D enhancement to be bypassed |
| code_invalid | output | 1 | Present code is not defined for the present mode |

## Verification
A wrong decode entry or a corrupted frame counter shows up directly as a strobe spacing that differs from the listed ratio. It is visible within one frame, at most 1152 ticks, or twice that with the pre-divide on. A wrong frame-clock threshold shows as a wrong high time within the same frame. A configuration register that loads at the wrong moment shows as a truncated frame, or as filter_class changing outside a strobe cycle, in the frame where the code was changed. A hold failure on an invalid code appears in the first frame after the invalid code is applied.

// File: rtl/srate_pkg.sv
package srate_pkg;

    localparam int CODE_W  = 5;
    localparam int RATIO_W = 11;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [CODE_W-1:0]  code_t;

    typedef enum logic [1:0] {
        FILT_A = 2'd0,
        FILT_B = 2'd1,
        FILT_C = 2'd2,
        FILT_D = 2'd3
    } filt_e;

    typedef struct packed {
        logic   valid;
        ratio_t ratio;
        filt_e  filt;
        logic   bypass;
    } rate_sel_t;

    typedef struct packed {
        ratio_t ratio;
        filt_e  filt;
        logic   bypass;
        logic   half;
    } clk_cfg_t;

    localparam ratio_t RESET_RATIO = ratio_t'(256);

    function automatic rate_sel_t mk_sel(input int r, input filt_e f, input logic b);
        rate_sel_t s;
        s.valid  = 1'b1;
        s.ratio  = ratio_t'(r);
        s.filt   = f;
        s.bypass = b;
        return s;
    endfunction

    function automatic rate_sel_t decode_rate(input logic usb, input code_t code);
        rate_sel_t s;
        s = '{valid: 1'b0, ratio: RESET_RATIO, filt: FILT_A, bypass: 1'b0};
        if (!usb) begin
            case (code)
                5'b00000: s = mk_sel(256,  FILT_A, 1'b0);
                5'b00001: s = mk_sel(384,  FILT_A, 1'b0);
                5'b01010: s = mk_sel(768,  FILT_A, 1'b0);
                5'b01011: s = mk_sel(1152, FILT_A, 1'b0);
                5'b01100: s = mk_sel(384,  FILT_A, 1'b0);
                5'b01101: s = mk_sel(576,  FILT_A, 1'b0);
                5'b01110: s = mk_sel(128,  FILT_B, 1'b1);
                5'b01111: s = mk_sel(192,  FILT_B, 1'b1);
                5'b10000: s = mk_sel(256,  FILT_A, 1'b0);
                5'b10001: s = mk_sel(384,  FILT_A, 1'b0);
                5'b11010: s = mk_sel(512,  FILT_A, 1'b0);
                5'b11011: s = mk_sel(768,  FILT_A, 1'b0);
                5'b11100: s = mk_sel(512,  FILT_A, 1'b0);
                5'b11101: s = mk_sel(768,  FILT_A, 1'b0);
                5'b11110: s = mk_sel(128,  FILT_B, 1'b1);
                5'b11111: s = mk_sel(192,  FILT_B, 1'b1);
                default:  ;
            endcase
        end else begin
            case (code)
                5'b00000: s = mk_sel(250, FILT_C, 1'b0);
                5'b01010: s = mk_sel(750, FILT_C, 1'b0);
                5'b01100: s = mk_sel(375, FILT_C, 1'b0);
                5'b01110: s = mk_sel(125, FILT_D, 1'b1);
                5'b10001: s = mk_sel(272, FILT_A, 1'b0);
                5'b11011: s = mk_sel(544, FILT_A, 1'b0);
                5'b11100: s = mk_sel(500, FILT_C, 1'b0);
                5'b11111: s = mk_sel(136, FILT_B, 1'b1);
                default:  ;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/srate_decode.sv
module srate_decode
    import srate_pkg::*;
(
    input  logic      usb,
    input  code_t     code,
    output rate_sel_t sel
);
    always_comb begin
        sel = decode_rate(usb, code);
    end
endmodule

// File: rtl/srate_prediv.sv
module srate_prediv #(
    parameter bit HALF_SUPPORT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic mclk_en,
    input  logic half,
    output logic tick
);
    generate
        if (HALF_SUPPORT) begin : g_half
            logic phase_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    phase_q <= 1'b0;
                end else if (mclk_en) begin
                    phase_q <= half ? ~phase_q : 1'b0;
                end
            end
            assign tick = mclk_en & (~half | phase_q);
        end else begin : g_full
            logic unused_half;
            assign unused_half = half;
            assign tick = mclk_en;
        end
    endgenerate
endmodule

// File: rtl/srate_frame_cnt.sv
module srate_frame_cnt #(
    parameter int W = 11,
    parameter int RST_RATIO = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cur_ratio,
    input  logic [W-1:0] nxt_ratio,
    output logic         wrap,
    output logic [W-1:0] cnt_q,
    output logic         stb_q,
    output logic         fclk_q
);
    localparam logic [W-1:0] CNT_RST = W'(RST_RATIO - 1);

    logic [W-1:0] cnt_d;
    logic [W-1:0] thr;
    logic         fclk_d;

    assign wrap = tick && (cnt_q == cur_ratio - 1'b1);

    always_comb begin
        cnt_d  = cnt_q;
        fclk_d = fclk_q;
        thr    = (wrap ? nxt_ratio : cur_ratio) >> 1;
        if (tick) begin
            cnt_d  = wrap ? '0 : cnt_q + 1'b1;
            fclk_d = (cnt_d < thr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CNT_RST;
            stb_q  <= 1'b0;
            fclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            stb_q  <= wrap;
            fclk_q <= fclk_d;
        end
    end
endmodule

// File: rtl/srate_div.sv
module srate_div
    import srate_pkg::*;
#(
    parameter bit HALF_SUPPORT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mclk_en,
    input  logic [CODE_W-1:0]   rate_code,
    input  logic                usb_mode,
    input  logic                half_mclk,
    output logic                sample_stb,
    output logic                frame_clk,
    output logic [1:0]          filter_class,
    output logic                bypass_3d,
    output logic                code_invalid
);
    rate_sel_t dec;
    clk_cfg_t  cfg_q;
    logic      tick;
    logic      wrap;
    ratio_t    nxt_ratio;
    ratio_t    cnt_q;
    ratio_t    act_ratio;

    srate_decode u_dec (
        .usb  (usb_mode),
        .code (rate_code),
        .sel  (dec)
    );

    srate_prediv #(.HALF_SUPPORT(HALF_SUPPORT)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .mclk_en (mclk_en),
        .half    (cfg_q.half),
        .tick    (tick)
    );

    assign act_ratio = cfg_q.ratio;
    assign nxt_ratio = dec.valid ? dec.ratio : cfg_q.ratio;

    srate_frame_cnt #(.W(RATIO_W), .RST_RATIO(int'(RESET_RATIO))) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cur_ratio (act_ratio),
        .nxt_ratio (nxt_ratio),
        .wrap      (wrap),
        .cnt_q     (cnt_q),
        .stb_q     (sample_stb),
        .fclk_q    (frame_clk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{ratio: RESET_RATIO, filt: FILT_A, bypass: 1'b0, half: 1'b0};
        end else if (wrap && dec.valid) begin
            cfg_q <= '{ratio: dec.ratio, filt: dec.filt, bypass: dec.bypass, half: half_mclk};
        end
    end

    assign filter_class = cfg_q.filt;
    assign bypass_3d    = cfg_q.bypass;
    assign code_invalid = ~dec.valid;
endmodule

// File: rtl/srate_div_chk.sv
module srate_div_chk #(
    parameter int W = 11
) (
    input logic         clk,
    input logic         rst,
    input logic         sample_stb,
    input logic         frame_clk,
    input logic [1:0]   filter_class,
    input logic         bypass_3d,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] ratio_q
);
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb); // R6

    AST_FCLK_RISE_AT_STB: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_clk) |-> sample_stb); // R6

    AST_FCLK_FALL_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_clk) |-> !sample_stb); // R7

    AST_CFG_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |-> ($stable(filter_class) && $stable(bypass_3d))); // R11

    AST_BYPASS_CLASS: assert property (@(posedge clk) disable iff (rst)
        bypass_3d |-> (filter_class == 2'd1 || filter_class == 2'd3)); // R9

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q < ratio_q); // R2
endmodule

bind srate_div srate_div_chk #(.W(srate_pkg::RATIO_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_stb   (sample_stb),
    .frame_clk    (frame_clk),
    .filter_class (filter_class),
    .bypass_3d    (bypass_3d),
    .cnt_q        (cnt_q),
    .ratio_q      (act_ratio)
);

// File: tb/srate_div_tb.sv
module srate_div_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mclk_en = 1'b0;
    logic [4:0] rate_code = 5'b00000;
    logic       usb_mode = 1'b0;
    logic       half_mclk = 1'b0;
    logic       sample_stb, frame_clk, bypass_3d, code_invalid;
    logic [1:0] filter_class;

    int total = 0;
    int bad = 0;
    int en_div = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    srate_div u_dut (
        .clk(clk), .rst(rst), .mclk_en(mclk_en), .rate_code(rate_code),
        .usb_mode(usb_mode), .half_mclk(half_mclk), .sample_stb(sample_stb),
        .frame_clk(frame_clk), .filter_class(filter_class), .bypass_3d(bypass_3d),
        .code_invalid(code_invalid)
    );

    initial begin
        int ph;
        ph = 0;
        forever begin
            @(posedge clk);
            #1;
            mclk_en = (en_div != 0) && (ph == 0);
            if (en_div != 0) ph = (ph + 1 >= en_div) ? 0 : ph + 1;
            else ph = 0;
        end
    end

    function automatic int exp_ratio(input bit usb, input logic [4:0] c);
        if (!usb) begin
            case (c)
                5'b00000, 5'b10000: return 256;
                5'b00001, 5'b01100, 5'b10001: return 384;
                5'b01010, 5'b11011, 5'b11101: return 768;
                5'b01011: return 1152;
                5'b01101: return 576;
                5'b01110, 5'b11110: return 128;
                5'b01111, 5'b11111: return 192;
                5'b11010, 5'b11100: return 512;
                default: return 0;
            endcase
        end
        case (c)
            5'b00000: return 250;
            5'b01010: return 750;
            5'b01100: return 375;
            5'b01110: return 125;
            5'b10001: return 272;
            5'b11011: return 544;
            5'b11100: return 500;
            5'b11111: return 136;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_filt(input bit usb, input logic [4:0] c);
        if (!usb) return (c[3:1] == 3'b111) ? 1 : 0;
        case (c)
            5'b00000, 5'b01010, 5'b01100, 5'b11100: return 2;
            5'b11111: return 1;
            5'b01110: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_byp(input bit usb, input logic [4:0] c);
        if (!usb) return (c[3:1] == 3'b111) ? 1 : 0;
        return (c == 5'b11111 || c == 5'b01110) ? 1 : 0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_stb();
        do @(negedge clk); while (!sample_stb);
    endtask

    task automatic measure(output int period, output int hi);
        period = 1;
        hi = int'(frame_clk);
        forever begin
            @(negedge clk);
            if (sample_stb) break;
            period++;
            hi += int'(frame_clk);
        end
    endtask

    initial begin
        int p, h, n;
        repeat (5) @(negedge clk);
        check("R1", "stb in reset", int'(sample_stb), 0);
        check("R1", "fclk in reset", int'(frame_clk), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check("R1", "filter after reset", int'(filter_class), 0);
        check("R1", "bypass after reset", int'(bypass_3d), 0);
        check("R5", "stb without enable", int'(sample_stb), 0);
        check("R5", "fclk without enable", int'(frame_clk), 0);
        en_div = 1;
        wait_stb();
        measure(p, h);
        check("R1", "first frame period", p, 256);

        for (int u = 0; u < 2; u++) begin
            for (int c = 0; c < 32; c++) begin
                @(negedge clk);
                usb_mode = u[0];
                rate_code = c[4:0];
                #1;
                n = exp_ratio(u[0], c[4:0]);
                check("R10", $sformatf("invalid flag u=%0d c=%0d", u, c),
                      int'(code_invalid), (n == 0) ? 1 : 0);
                if (n != 0) begin
                    wait_stb();
                    check("R8", $sformatf("filter u=%0d c=%0d", u, c), int'(filter_class), exp_filt(u[0], c[4:0]));
                    check("R9", $sformatf("bypass u=%0d c=%0d", u, c), int'(bypass_3d), exp_byp(u[0], c[4:0]));
                    measure(p, h);
                    check(u ? "R3" : "R2", $sformatf("period u=%0d c=%0d", u, c), p, n);
                    check("R7", $sformatf("high time u=%0d c=%0d", u, c), h, n / 2);
                end
            end
        end

        // R10 hold of ratio and class across invalid codes
        usb_mode = 1'b0; rate_code = 5'b00000;
        wait_stb();
        @(negedge clk); rate_code = 5'b00010; #1;
        check("R10", "invalid normal 00010", int'(code_invalid), 1);
        wait_stb();
        measure(p, h);
        check("R10", "held period after invalid", p, 256);
        check("R10", "held filter after invalid", int'(filter_class), 0);
        usb_mode = 1'b1; rate_code = 5'b01110;
        wait_stb();
        @(negedge clk); rate_code = 5'b00001; half_mclk = 1'b1; #1;
        check("R10", "invalid usb 00001", int'(code_invalid), 1);
        wait_stb();
        measure(p, h);
        check("R10", "held usb period", p, 125);
        check("R10", "held usb filter D", int'(filter_class), 3);
        check("R10", "held usb bypass", int'(bypass_3d), 1);
        half_mclk = 1'b0;

        // R11 mid-frame change does not truncate
        usb_mode = 1'b0; rate_code = 5'b00000;
        wait_stb();
        p = 1;
        repeat (20) begin @(negedge clk); p++; end
        rate_code = 5'b01110;
        forever begin
            @(negedge clk);
            if (sample_stb) break;
            p++;
        end
        check("R11", "frame in progress kept length", p, 256);
        check("R11", "new filter at boundary", int'(filter_class), 1);
        measure(p, h);
        check("R11", "next frame new length", p, 128);

        // R4 pre-divide
        half_mclk = 1'b1;
        wait_stb();
        measure(p, h);
        check("R4", "half normal 128 period", p, 256);
        check("R4", "half normal 128 high", h, 128);
        usb_mode = 1'b1; rate_code = 5'b01110;
        wait_stb();
        measure(p, h);
        check("R4", "half usb 125 period", p, 250);
        check("R4", "half usb 125 high", h, 124);

        // R5 sparse enables
        half_mclk = 1'b0;
        wait_stb();
        en_div = 3;
        wait_stb();
        measure(p, h);
        check("R5", "enable every 3rd period", p, 375);
        check("R5", "enable every 3rd high", h, 186);

        // R6 strobe width
        @(negedge clk);
        check("R6", "strobe drops after one cycle", int'(sample_stb), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule